// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves frames from memory to a byte stream under the control of a ring of transmit descriptors. The descriptors sit in a small on-chip store that a host fills and reads back through a simple indexed port. Each entry has three words: a control word with an ownership flag, packet delimiters and a 24-bit buffer address; a 16-bit length held as a negative two's-complement byte count; and a secondary status word. The engine walks the ring in order. For every entry whose ownership flag is set it fetches the buffer one byte at a time over a read port with one cycle of latency. It presents each byte on a valid/ready stream, writes completion status into the entry, then returns the entry to the host and pulses a transmit-done event.

The ring length is a log2 code captured when the engine is started. When the engine meets an entry it does not own, it parks. It looks at that entry again on a host poll-demand strobe or on a periodic poll tick. If the read port reports that a byte is not available, the frame is cut short and the entry is marked as failed with a buffer-underflow cause. The transmitter then stays halted until it is started again.

Top module: `txr_engine`

## Requirements
- R1: After reset the engine is stopped. `tx_valid`, `tx_done` and `mem_rd_en` are low, and no descriptor is read or served until `start` is pulsed, even if an entry is owned.
- R2: The engine serves an entry only while bit 31 (ownership) of its control word is 1. When it finds bit 31 at 0 it issues no memory reads and sends nothing until a poll event re-checks the entry.
- R3: The byte count is 65536 minus the 16-bit length field (the negation of the field; a zero field means 65536). Bytes are read one at a time from ascending addresses, starting at control-word bits 23:0. `tx_last` is high only on the final byte.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values until the transfer completes.
- R5: On normal completion the secondary status word becomes 0x0000, and control-word bits 30 (error) and 28:27 (retry count) are written 0. Bits 25:24 (start/end of packet) and 23:0 are preserved. Bit 31 is cleared in a later cycle than the status write.
- R6: `tx_done` is high for exactly one cycle per completed entry. In that cycle the host read port already shows bit 31 of that entry as 0.
- R7: The entry index advances modulo 2^code, where code is `ring_code` captured at `start`, limited to MAX_LOG. With code 2, entry 3 is followed by entry 0.
- R8: A `poll_demand` pulse while the engine is parked makes it re-check the current entry at once, without waiting for the periodic tick.
- R9: While parked, the engine re-checks the current entry by itself every POLL_CYCLES cycles.
- R10: If `mem_rd_ok` is low when a byte returns, that byte and the rest of the frame are not sent and no `tx_last` is given. The entry gets bit 30 set, secondary status 0x4000, bit 31 cleared and a `tx_done` pulse. The engine then ignores owned entries and poll demands until the next `start`.
- R11: `stop` abandons any frame in progress at once, with no write-back, and `start` returns the index to entry 0. The abandoned entry is then sent again from its first byte.
- R12: A host write to one entry and the engine's write-back to another entry in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: capture ring code, index to 0, clear halt, begin fetching |
| stop | input | 1 | Pulse: abandon work, index to 0, go idle |
| poll_demand | input | 1 | Pulse: re-check the current entry now |
| ring_code | input | 3 | Log2 of ring entries, captured at start |
| hw_en | input | 1 | Host descriptor write enable |
| hw_idx | input | MAX_LOG | Host write entry index |
| hw_sel | input | 2 | Word select: 0 control, 1 length, 2 status |
| hw_data | input | 32 | Host write data (16-bit words use bits 15:0) |
| hr_idx | input | MAX_LOG | Host read entry index |
| hr_sel | input | 2 | Host read word select, same coding as hw_sel |
| hr_data | output | 32 | Host read data, combinational |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | 24 | Byte read address |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| mem_rd_ok | input | 1 | Read data available, same cycle as mem_rd_data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Stream sink ready |
| tx_done | output | 1 | One-cycle entry completion event |

## Verification
The engine's write-back to the active entry can land in the same cycle as a host write to a different entry of the descriptor store. To provoke this, the bench writes a new value into another entry's status word on every cycle for the whole frame, so one of those writes is certain to coincide with the status write and with the ownership release. It then reads both entries back. The host's entry must hold the last value written, and the served entry must show zero status and a cleared ownership flag. A lost or overwritten value in either entry shows that one writer blocked the other.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_FETCH,
    ST_WAIT,
    ST_REQ,
    ST_DATA,
    ST_SEND,
    ST_WB,
    ST_REL,
    ST_HALT
  } txr_state_e;

  localparam int          OWN_BIT       = 31;
  localparam int          ERR_BIT       = 30;
  localparam logic [15:0] STS_UNDERFLOW = 16'h4000;
  localparam logic [1:0]  SEL_CTRL      = 2'd0;
  localparam logic [1:0]  SEL_LEN       = 2'd1;
  localparam logic [1:0]  SEL_STS       = 2'd2;

endpackage

// File: rtl/txr_desc_mem.sv
module txr_desc_mem #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic [IDX_W-1:0] hw_idx,
  input  logic [1:0]       hw_sel,
  input  logic [31:0]      hw_data,
  input  logic [IDX_W-1:0] hr_idx,
  input  logic [1:0]       hr_sel,
  output logic [31:0]      hr_data,
  input  logic [IDX_W-1:0] e_idx,
  output logic [31:0]      e_ctrl,
  output logic [15:0]      e_len,
  input  logic             e_ctrl_we,
  input  logic [31:0]      e_ctrl_wd,
  input  logic             e_sts_we,
  input  logic [15:0]      e_sts_wd
);
  import txr_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  logic [31:0] ctrl_all [DEPTH];
  logic [15:0] len_all  [DEPTH];
  logic [15:0] sts_all  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gen_ent
    logic [31:0] ctrl_q, ctrl_n;
    logic [15:0] len_q, len_n, sts_q, sts_n;
    logic        host_hit, eng_ctrl_hit, eng_sts_hit, ent_we;

    always_comb begin
      host_hit     = hw_en && (hw_idx == IDX_W'(g));
      eng_ctrl_hit = e_ctrl_we && (e_idx == IDX_W'(g));
      eng_sts_hit  = e_sts_we && (e_idx == IDX_W'(g));
      ctrl_n = ctrl_q;
      len_n  = len_q;
      sts_n  = sts_q;
      if (host_hit) begin
        case (hw_sel)
          SEL_CTRL: ctrl_n = hw_data;
          SEL_LEN:  len_n  = hw_data[15:0];
          SEL_STS:  sts_n  = hw_data[15:0];
          default:  ;
        endcase
      end
      if (eng_ctrl_hit) ctrl_n = e_ctrl_wd;
      if (eng_sts_hit)  sts_n  = e_sts_wd;
      ent_we = host_hit || eng_ctrl_hit || eng_sts_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        len_q  <= '0;
        sts_q  <= '0;
      end else if (ent_we) begin
        ctrl_q <= ctrl_n;
        len_q  <= len_n;
        sts_q  <= sts_n;
      end
    end

    assign ctrl_all[g] = ctrl_q;
    assign len_all[g]  = len_q;
    assign sts_all[g]  = sts_q;
  end

  always_comb begin
    case (hr_sel)
      SEL_CTRL: hr_data = ctrl_all[hr_idx];
      SEL_LEN:  hr_data = {16'h0000, len_all[hr_idx]};
      SEL_STS:  hr_data = {16'h0000, sts_all[hr_idx]};
      default:  hr_data = '0;
    endcase
  end

  assign e_ctrl = ctrl_all[e_idx];
  assign e_len  = len_all[e_idx];

  AST_RELEASE_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (e_ctrl_we && !e_ctrl_wd[OWN_BIT]) |-> $past(e_sts_we)); // R5

  AST_RELEASE_SAME_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (e_ctrl_we && !e_ctrl_wd[OWN_BIT]) |-> (e_idx == $past(e_idx))); // R5

endmodule

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
  parameter int POLL_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(POLL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(POLL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    tick   = run && (cnt_q == CNT_END);
    cnt_en = run || (cnt_q != '0);
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R9

endmodule

// File: rtl/txr_seq.sv
module txr_seq #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             poll_demand,
  input  logic             tick,
  input  logic [2:0]       ring_code,
  output logic             waiting,
  output logic [IDX_W-1:0] e_idx,
  input  logic [31:0]      e_ctrl,
  input  logic [15:0]      e_len,
  output logic             e_ctrl_we,
  output logic [31:0]      e_ctrl_wd,
  output logic             e_sts_we,
  output logic [15:0]      e_sts_wd,
  output logic             mem_rd_en,
  output logic [23:0]      mem_addr,
  input  logic [7:0]       mem_rd_data,
  input  logic             mem_rd_ok,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             tx_ready,
  output logic             tx_done
);
  import txr_pkg::*;

  localparam int CNT_W = 17;
  localparam logic [CNT_W-1:0] CNT_BASE = 17'h10000;

  txr_state_e       st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n, mask_q, mask_n;
  logic [23:0]      addr_q, addr_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic [7:0]       byte_q, byte_n;
  logic             last_q, last_n, err_q, err_n, done_q, done_n;

  function automatic logic [IDX_W-1:0] mask_of(input logic [2:0] code);
    int eff;
    eff = (int'(code) > IDX_W) ? IDX_W : int'(code);
    return IDX_W'((1 << eff) - 1);
  endfunction

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    mask_n = mask_q;
    addr_n = addr_q;
    rem_n  = rem_q;
    byte_n = byte_q;
    last_n = last_q;
    err_n  = err_q;
    done_n = 1'b0;
    if (stop) begin
      st_n  = ST_OFF;
      idx_n = '0;
    end else if (start) begin
      st_n   = ST_FETCH;
      idx_n  = '0;
      mask_n = mask_of(ring_code);
      err_n  = 1'b0;
    end else begin
      case (st_q)
        ST_FETCH: begin
          if (e_ctrl[OWN_BIT]) begin
            addr_n = e_ctrl[23:0];
            rem_n  = CNT_BASE - {1'b0, e_len};
            err_n  = 1'b0;
            st_n   = ST_REQ;
          end else begin
            st_n = ST_WAIT;
          end
        end
        ST_WAIT: if (poll_demand || tick) st_n = ST_FETCH;
        ST_REQ:  st_n = ST_DATA;
        ST_DATA: begin
          if (mem_rd_ok) begin
            byte_n = mem_rd_data;
            last_n = (rem_q == CNT_W'(1));
            st_n   = ST_SEND;
          end else begin
            err_n = 1'b1;
            st_n  = ST_WB;
          end
        end
        ST_SEND: begin
          if (tx_ready) begin
            if (last_q) begin
              st_n = ST_WB;
            end else begin
              addr_n = addr_q + 1'b1;
              rem_n  = rem_q - 1'b1;
              st_n   = ST_REQ;
            end
          end
        end
        ST_WB:   st_n = ST_REL;
        ST_REL: begin
          done_n = 1'b1;
          if (err_q) begin
            st_n = ST_HALT;
          end else begin
            idx_n = (idx_q + 1'b1) & mask_q;
            st_n  = ST_FETCH;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      idx_q  <= '0;
      mask_q <= '0;
      addr_q <= '0;
      rem_q  <= '0;
      byte_q <= '0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      mask_q <= mask_n;
      addr_q <= addr_n;
      rem_q  <= rem_n;
      byte_q <= byte_n;
      last_q <= last_n;
      err_q  <= err_n;
      done_q <= done_n;
    end
  end

  always_comb begin
    waiting   = (st_q == ST_WAIT);
    e_idx     = idx_q;
    mem_rd_en = (st_q == ST_REQ);
    mem_addr  = addr_q;
    tx_valid  = (st_q == ST_SEND);
    tx_data   = byte_q;
    tx_last   = (st_q == ST_SEND) && last_q;
    tx_done   = done_q;
    e_sts_we  = (st_q == ST_WB);
    e_sts_wd  = err_q ? STS_UNDERFLOW : 16'h0000;
    e_ctrl_we = (st_q == ST_WB) || (st_q == ST_REL);
    if (st_q == ST_WB) e_ctrl_wd = {1'b1, err_q, e_ctrl[29], 2'b00, e_ctrl[26:0]};
    else               e_ctrl_wd = {1'b0, e_ctrl[30:0]};
  end

  AST_FETCH_ONLY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REQ && $past(st_q) == ST_FETCH) |-> $past(e_ctrl[OWN_BIT])); // R2

  AST_ONE_READ_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R3

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !stop && !start) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done); // R6

  AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q & ~mask_q) == '0); // R7

  AST_UNDERFLOW_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && !mem_rd_ok && !stop && !start) |=> (e_sts_we && e_sts_wd == STS_UNDERFLOW)); // R10

endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
  parameter int MAX_LOG     = 4,
  parameter int POLL_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stop,
  input  logic               poll_demand,
  input  logic [2:0]         ring_code,
  input  logic               hw_en,
  input  logic [MAX_LOG-1:0] hw_idx,
  input  logic [1:0]         hw_sel,
  input  logic [31:0]        hw_data,
  input  logic [MAX_LOG-1:0] hr_idx,
  input  logic [1:0]         hr_sel,
  output logic [31:0]        hr_data,
  output logic               mem_rd_en,
  output logic [23:0]        mem_addr,
  input  logic [7:0]         mem_rd_data,
  input  logic               mem_rd_ok,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  output logic               tx_last,
  input  logic               tx_ready,
  output logic               tx_done
);

  logic [MAX_LOG-1:0] e_idx;
  logic [31:0]        e_ctrl, e_ctrl_wd;
  logic [15:0]        e_len, e_sts_wd;
  logic               e_ctrl_we, e_sts_we;
  logic               waiting, tick;

  txr_desc_mem #(.IDX_W(MAX_LOG)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_en     (hw_en),
    .hw_idx    (hw_idx),
    .hw_sel    (hw_sel),
    .hw_data   (hw_data),
    .hr_idx    (hr_idx),
    .hr_sel    (hr_sel),
    .hr_data   (hr_data),
    .e_idx     (e_idx),
    .e_ctrl    (e_ctrl),
    .e_len     (e_len),
    .e_ctrl_we (e_ctrl_we),
    .e_ctrl_wd (e_ctrl_wd),
    .e_sts_we  (e_sts_we),
    .e_sts_wd  (e_sts_wd)
  );

  txr_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (waiting),
    .tick  (tick)
  );

  txr_seq #(.IDX_W(MAX_LOG)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .stop        (stop),
    .poll_demand (poll_demand),
    .tick        (tick),
    .ring_code   (ring_code),
    .waiting     (waiting),
    .e_idx       (e_idx),
    .e_ctrl      (e_ctrl),
    .e_len       (e_len),
    .e_ctrl_we   (e_ctrl_we),
    .e_ctrl_wd   (e_ctrl_wd),
    .e_sts_we    (e_sts_we),
    .e_sts_wd    (e_sts_wd),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rd_data (mem_rd_data),
    .mem_rd_ok   (mem_rd_ok),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .tx_ready    (tx_ready),
    .tx_done     (tx_done)
  );

endmodule

// File: tb/txr_engine_tb_top.sv
`timescale 1ns/1ps
module txr_engine_tb_top;
  localparam int LOG  = 4;
  localparam int POLL = 100;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0, stop = 1'b0, poll_demand = 1'b0;
  logic [2:0]       ring_code = 3'd2;
  logic             hw_en = 1'b0;
  logic [LOG-1:0]   hw_idx = '0;
  logic [1:0]       hw_sel = '0;
  logic [31:0]      hw_data = '0;
  logic [LOG-1:0]   hr_idx = '0;
  logic [1:0]       hr_sel = '0;
  logic [31:0]      hr_data;
  logic             mem_rd_en;
  logic [23:0]      mem_addr;
  logic [7:0]       mem_rd_data = '0;
  logic             mem_rd_ok = 1'b0;
  logic             tx_valid, tx_last, tx_done;
  logic [7:0]       tx_data;
  logic             tx_ready = 1'b1;

  int  checks = 0, fails = 0;
  int  cap_n = 0, done_cnt = 0, rd_cnt = 0, stab_err = 0;
  logic [7:0] cap_data [0:127];
  logic       cap_last [0:127];
  int  ready_mode = 0;
  logic [23:0] bad_addr = 24'hFFFFFF;
  bit  finished = 0;

  always #2 clk = ~clk;

  txr_engine #(.MAX_LOG(LOG), .POLL_CYCLES(POLL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .poll_demand(poll_demand),
    .ring_code(ring_code), .hw_en(hw_en), .hw_idx(hw_idx), .hw_sel(hw_sel), .hw_data(hw_data),
    .hr_idx(hr_idx), .hr_sel(hr_sel), .hr_data(hr_data), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .mem_rd_ok(mem_rd_ok),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .tx_done(tx_done)
  );

  function automatic logic [7:0] exp_byte(input logic [23:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // byte memory model: answers one cycle after each request
  initial begin
    logic        pend;
    logic [23:0] pa;
    forever begin
      @(negedge clk);
      pend = mem_rd_en;
      pa   = mem_addr;
      @(posedge clk);
      #1;
      mem_rd_data = exp_byte(pa);
      mem_rd_ok   = pend && (pa != bad_addr);
    end
  end

  // sink ready pattern
  initial begin
    logic tog;
    tog = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      tog = ~tog;
      tx_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? tog : 1'b0;
    end
  end

  // observers
  initial begin
    logic       stall_prev;
    logic [7:0] data_prev;
    logic       last_prev;
    stall_prev = 1'b0;
    data_prev  = '0;
    last_prev  = 1'b0;
    forever begin
      @(negedge clk);
      if (stall_prev && tx_valid && (tx_data != data_prev || tx_last != last_prev)) stab_err++;
      stall_prev = tx_valid && !tx_ready;
      data_prev  = tx_data;
      last_prev  = tx_last;
      if (tx_valid && tx_ready && cap_n < 128) begin
        cap_data[cap_n] = tx_data;
        cap_last[cap_n] = tx_last;
        cap_n++;
      end
      if (tx_done) done_cnt++;
      if (mem_rd_en) rd_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hwrite(input int idx, input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    hw_en = 1'b1; hw_idx = LOG'(idx); hw_sel = sel; hw_data = d;
    @(posedge clk); #1;
    hw_en = 1'b0;
  endtask

  task automatic hread(input int idx, input logic [1:0] sel, output logic [31:0] d);
    hr_idx = LOG'(idx); hr_sel = sel;
    #0.5;
    d = hr_data;
  endtask

  task automatic give(input int idx, input logic [23:0] addr, input int n);
    hwrite(idx, 2'd1, {16'h0000, 16'(-n)});
    hwrite(idx, 2'd2, 32'h0);
    hwrite(idx, 2'd0, {8'h83, addr});
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #1;
    if (which == 0) start = 1'b1; else if (which == 1) stop = 1'b1; else poll_demand = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; stop = 1'b0; poll_demand = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_done(input int idx, input int maxc, input string req);
    bit seen;
    seen = 0;
    hr_idx = LOG'(idx); hr_sel = 2'd0;
    for (int c = 0; c < maxc && !seen; c++) begin
      @(negedge clk);
      if (tx_done) begin
        seen = 1;
        chk(hr_data[31] == 1'b0, "R6", "ownership at done", hr_data[31], 0);
      end
    end
    chk(seen, req, "done pulse seen", seen, 1);
    @(posedge clk); #1;
  endtask

  task automatic chk_frame(input int base, input logic [23:0] addr, input int n,
                           input bit with_last, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (cap_data[base+i] != exp_byte(addr + 24'(i))) bad++;
      if (cap_last[base+i] != (with_last && i == n-1)) bad++;
    end
    chk(bad == 0, req, "frame content/last mismatches", bad, 0);
  endtask

  task automatic t_reset;
    int rd0;
    chk(!tx_valid && !tx_done, "R1", "stream/done after reset", {tx_valid, tx_done}, 0);
    chk(!mem_rd_en, "R1", "read enable after reset", mem_rd_en, 0);
    rd0 = rd_cnt;
    give(0, 24'h000100, 3);
    idle(20);
    chk(rd_cnt == rd0 && cap_n == 0, "R1", "activity before start", rd_cnt - rd0, 0);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    int base;
    base = cap_n;
    ring_code = 3'd2;
    pulse(0);
    wait_done(0, 60, "R3");
    chk(cap_n - base == 3, "R3", "byte count", cap_n - base, 3);
    chk_frame(base, 24'h000100, 3, 1, "R3");
    hread(0, 2'd0, d);
    chk(d == 32'h0300_0100, "R5", "control word after completion", d, 32'h0300_0100);
    hread(0, 2'd2, d);
    chk(d == 32'h0, "R5", "status after completion", d, 0);
    chk(done_cnt == 1, "R6", "done pulse count", done_cnt, 1);
  endtask

  task automatic t_poll_backpressure;
    int rd0, base;
    rd0 = rd_cnt;
    idle(10);
    chk(rd_cnt == rd0, "R2", "reads while entry not owned", rd_cnt - rd0, 0);
    base = cap_n;
    ready_mode = 1;
    give(1, 24'h000120, 4);
    pulse(2);
    wait_done(1, 40, "R8");
    chk_frame(base, 24'h000120, 4, 1, "R4");
    chk(stab_err == 0, "R4", "stream changed while stalled", stab_err, 0);
    ready_mode = 0;
  endtask

  task automatic t_tick;
    int rd0, first;
    rd0 = rd_cnt;
    first = -1;
    give(2, 24'h000140, 2);
    for (int c = 0; c < 200 && first < 0; c++) begin
      @(negedge clk);
      if (rd_cnt != rd0) first = c;
    end
    chk(first >= 60 && first <= 140, "R9", "cycles until periodic re-check", first, POLL);
    wait_done(2, 40, "R9");
  endtask

  task automatic t_wrap;
    int base;
    base = cap_n;
    give(3, 24'h000160, 2);
    give(0, 24'h000180, 2);
    pulse(2);
    wait_done(3, 60, "R7");
    wait_done(0, 60, "R7");
    chk_frame(base, 24'h000160, 2, 1, "R7");
    chk_frame(base + 2, 24'h000180, 2, 1, "R7");
  endtask

  task automatic t_collide;
    logic [31:0] d;
    int base, d0;
    base = cap_n;
    d0 = done_cnt;
    give(1, 24'h0001A0, 6);
    pulse(2);
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      hw_en = 1'b1; hw_idx = LOG'(2); hw_sel = 2'd2; hw_data = 32'h1000 + 32'(k);
    end
    @(posedge clk); #1;
    hw_en = 1'b0;
    chk(done_cnt == d0 + 1, "R12", "frame completed during host writes", done_cnt - d0, 1);
    chk_frame(base, 24'h0001A0, 6, 1, "R12");
    hread(2, 2'd2, d);
    chk(d == 32'h1027, "R12", "host-written status of other entry", d, 32'h1027);
    hread(1, 2'd0, d);
    chk(d == 32'h0300_01A0, "R12", "engine write-back of served entry", d, 32'h0300_01A0);
  endtask

  task automatic t_underflow;
    logic [31:0] d;
    int base, rd0, d0;
    base = cap_n;
    give(2, 24'h0001C0, 5);
    bad_addr = 24'h0001C2;
    pulse(2);
    wait_done(2, 60, "R10");
    bad_addr = 24'hFFFFFF;
    chk(cap_n - base == 2, "R10", "bytes sent before underflow", cap_n - base, 2);
    chk_frame(base, 24'h0001C0, 2, 0, "R10");
    hread(2, 2'd0, d);
    chk(d == 32'h4300_01C0, "R10", "control word after underflow", d, 32'h4300_01C0);
    hread(2, 2'd2, d);
    chk(d == 32'h4000, "R10", "underflow cause", d, 32'h4000);
    rd0 = rd_cnt;
    d0 = done_cnt;
    give(3, 24'h0001E0, 2);
    pulse(2);
    idle(40);
    chk(rd_cnt == rd0 && done_cnt == d0, "R10", "activity while halted", rd_cnt - rd0, 0);
  endtask

  task automatic t_restart;
    logic [31:0] d;
    int rd0, base;
    rd0 = rd_cnt;
    pulse(0);
    idle(10);
    chk(rd_cnt == rd0, "R11", "restart did not resume at entry 0", rd_cnt - rd0, 0);
    ready_mode = 2;
    give(0, 24'h000200, 3);
    pulse(2);
    for (int c = 0; c < 30 && !tx_valid; c++) @(negedge clk);
    pulse(1);
    chk(!tx_valid, "R11", "stream after stop", tx_valid, 0);
    hread(0, 2'd0, d);
    chk(d == 32'h8300_0200, "R11", "entry untouched by stop", d, 32'h8300_0200);
    ready_mode = 0;
    base = cap_n;
    pulse(0);
    wait_done(0, 60, "R11");
    chk_frame(base, 24'h000200, 3, 1, "R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);
    t_reset;
    t_basic;
    t_poll_backpressure;
    t_tick;
    t_wrap;
    t_collide;
    t_underflow;
    t_restart;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule